// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block decides, every cycle, where the two ALU operands of the instruction in the execute stage come from, and whether the instruction in decode must wait. A five-stage in-order pipeline uses it. The block keeps its own copy of the register tags that travel down the pipeline: source numbers, destination number, write-enable and load flag. These tags move from decode into execute, then to the memory stage, then to writeback. Forwarding compares the execute-stage source numbers with the destinations of the two older instructions ahead of it.

The forwarding path cannot cover a load whose value is read by the instruction right behind it. In that case the unit raises a stall that freezes the fetch address and the fetch/decode register for one cycle. In the same cycle it squashes the tags entering execute to zero, which inserts a bubble. When the held instruction is presented again, the loaded value is in the writeback stage and is forwarded from there. A writeback and a decode read of the same register need nothing from this unit, because the register file writes before it reads within a cycle. Branch resolution and the register file itself lie outside the block.

Top module: `hzd_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, both operand selects are 2'b00, stall and bubble are 0, and the writeback write-enable is 0.
- R2: If the instruction one ahead of the execute instruction writes a nonzero register that the execute instruction reads, that operand's select is 2'b10.
- R3: If only the instruction two ahead writes such a register, that operand's select is 2'b01.
- R4: When both older instructions write the same source register, the select is 2'b10 (the nearer result wins).
- R5: Register 0 never produces a forwarding select other than 2'b00, and never causes a stall.
- R6: A destination whose write-enable is low never produces a forwarding match.
- R7: If the execute instruction is a load whose nonzero destination equals either decode source register, stall and bubble are both 1 in that cycle. They are 0 in the next cycle.
- R8: After that single stall cycle, the dependent instruction reaches execute and receives the loaded value with select 2'b01.
- R9: A non-load producer directly ahead of a reader causes no stall.
- R10: A producer three instructions ahead of a reader gives select 2'b00, because the register file serves that case.
- R11: The writeback destination and write-enable equal the decode destination and write-enable accepted three cycles earlier. A bubble reaches writeback with write-enable 0.
- R12: Operand A (select pins fwdSelA) is decided only from the first decode source (decRs), and operand B only from the second (decRt). The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decRs | input | REG_ADDR_W | First source register of the decode instruction |
| decRt | input | REG_ADDR_W | Second source register of the decode instruction |
| decDst | input | REG_ADDR_W | Destination register of the decode instruction |
| decRegWrite | input | 1 | Decode instruction writes its destination |
| decMemRead | input | 1 | Decode instruction is a load |
| fwdSelA | output | 2 | Source select for ALU operand A (00 regfile, 01 writeback, 10 memory stage) |
| fwdSelB | output | 2 | Source select for ALU operand B |
| stall | output | 1 | Hold the fetch address and the fetch/decode register |
| bubble | output | 1 | Zero the control tags entering execute |
| wbDst | output | REG_ADDR_W | Destination register of the writeback instruction |
| wbRegWrite | output | 1 | Writeback instruction writes its destination |

## Verification
The bench builds the unit with the default 5-bit register number. This covers register 0 and arbitrary nonzero register numbers, so every pipeline distance from one to three can be reached. The tests include a load-use dependency on either source, two writers of the same register in flight, and zero-register or write-disabled destinations that must not match. A reference model in the bench tracks each instruction through the stage slots and predicts selects, stall and the writeback tags for every cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source codes; the ALU input mux decodes these values.
  typedef enum logic [1:0] {
    FWD_REGFILE  = 2'b00,
    FWD_WBSTAGE  = 2'b01,
    FWD_MEMSTAGE = 2'b10
  } fwdSel_e;

  // Strobes from hazard control to the tag pipeline.
  typedef struct packed {
    logic holdFront;
    logic injectBubble;
  } hzdStrobe_t;

  localparam int NUM_OPERANDS = 2;

endpackage

// File: rtl/hzd_tag_pipe.sv
module hzd_tag_pipe
  import hzd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  hzdStrobe_t                             strb,
  input  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] decSrc,
  input  logic [REG_ADDR_W-1:0]                  decDst,
  input  logic                                   decRegWrite,
  input  logic                                   decMemRead,
  output logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] exSrc,
  output logic [REG_ADDR_W-1:0]                  exDst,
  output logic                                   exMemRead,
  output logic [REG_ADDR_W-1:0]                  memDst,
  output logic                                   memRegWrite,
  output logic [REG_ADDR_W-1:0]                  wbDst,
  output logic                                   wbRegWrite
);

  logic exRegWrite;
  logic squash;

  // A held decode slot must not also enter execute: both strobes squash.
  assign squash = strb.injectBubble | strb.holdFront;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exSrc       <= '0;
      exDst       <= '0;
      exRegWrite  <= 1'b0;
      exMemRead   <= 1'b0;
      memDst      <= '0;
      memRegWrite <= 1'b0;
      wbDst       <= '0;
      wbRegWrite  <= 1'b0;
    end else begin
      if (squash) begin
        exSrc      <= '0;
        exDst      <= '0;
        exRegWrite <= 1'b0;
        exMemRead  <= 1'b0;
      end else begin
        exSrc      <= decSrc;
        exDst      <= decDst;
        exRegWrite <= decRegWrite;
        exMemRead  <= decMemRead;
      end
      memDst      <= exDst;
      memRegWrite <= exRegWrite;
      wbDst       <= memDst;
      wbRegWrite  <= memRegWrite;
    end
  end

endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] decSrc,
  input  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] exSrc,
  input  logic [REG_ADDR_W-1:0]                  exDst,
  input  logic                                   exMemRead,
  input  logic [REG_ADDR_W-1:0]                  memDst,
  input  logic                                   memRegWrite,
  input  logic [REG_ADDR_W-1:0]                  wbDst,
  input  logic                                   wbRegWrite,
  output logic [NUM_OPERANDS-1:0][1:0]           fwdSel,
  output hzdStrobe_t                             strb
);

  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic memLive, wbLive, loadLive;
  logic [NUM_OPERANDS-1:0] useHit;

  assign memLive  = memRegWrite && (memDst != ZERO_REG);
  assign wbLive   = wbRegWrite  && (wbDst  != ZERO_REG);
  assign loadLive = exMemRead   && (exDst  != ZERO_REG);

  for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_operand
    logic memHit, wbHit;
    assign memHit    = memLive && (memDst == exSrc[g]);
    assign wbHit     = wbLive  && (wbDst  == exSrc[g]);
    assign useHit[g] = loadLive && (exDst == decSrc[g]);

    always_comb begin
      if (memHit)     fwdSel[g] = FWD_MEMSTAGE;
      else if (wbHit) fwdSel[g] = FWD_WBSTAGE;
      else            fwdSel[g] = FWD_REGFILE;
    end
  end

  always_comb begin
    strb.holdFront    = |useHit;
    strb.injectBubble = |useHit;
  end

endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
  import hzd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] decRs,
  input  logic [REG_ADDR_W-1:0] decRt,
  input  logic [REG_ADDR_W-1:0] decDst,
  input  logic                  decRegWrite,
  input  logic                  decMemRead,
  output logic [1:0]            fwdSelA,
  output logic [1:0]            fwdSelB,
  output logic                  stall,
  output logic                  bubble,
  output logic [REG_ADDR_W-1:0] wbDst,
  output logic                  wbRegWrite
);

  logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] decSrc, exSrc;
  logic [REG_ADDR_W-1:0] exDst, memDst;
  logic exMemRead, memRegWrite;
  logic [NUM_OPERANDS-1:0][1:0] fwdSel;
  hzdStrobe_t strb;

  assign decSrc[0] = decRs;
  assign decSrc[1] = decRt;

  hzd_tag_pipe #(.REG_ADDR_W(REG_ADDR_W)) u_pipe (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .decSrc      (decSrc),
    .decDst      (decDst),
    .decRegWrite (decRegWrite),
    .decMemRead  (decMemRead),
    .exSrc       (exSrc),
    .exDst       (exDst),
    .exMemRead   (exMemRead),
    .memDst      (memDst),
    .memRegWrite (memRegWrite),
    .wbDst       (wbDst),
    .wbRegWrite  (wbRegWrite)
  );

  hzd_detect #(.REG_ADDR_W(REG_ADDR_W)) u_ctl (
    .decSrc      (decSrc),
    .exSrc       (exSrc),
    .exDst       (exDst),
    .exMemRead   (exMemRead),
    .memDst      (memDst),
    .memRegWrite (memRegWrite),
    .wbDst       (wbDst),
    .wbRegWrite  (wbRegWrite),
    .fwdSel      (fwdSel),
    .strb        (strb)
  );

  assign fwdSelA = fwdSel[0];
  assign fwdSelB = fwdSel[1];
  assign stall   = strb.holdFront;
  assign bubble  = strb.injectBubble;

endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
  parameter int REG_ADDR_W = 5
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] decRs,
  input logic [REG_ADDR_W-1:0] decRt,
  input logic                  decRegWrite,
  input logic [1:0]            fwdSelA,
  input logic [1:0]            fwdSelB,
  input logic                  stall,
  input logic                  bubble,
  input logic                  wbRegWrite
);

  // R7: a load-use interlock never lasts more than one cycle
  p_one_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  // R12: the unused select code never leaves the block
  p_legal_sel_a_r12: assert property (@(posedge clk) disable iff (!rstN)
    fwdSelA != 2'b11);
  p_legal_sel_b_r12: assert property (@(posedge clk) disable iff (!rstN)
    fwdSelB != 2'b11);

  // R5: a decode instruction reading only register 0 never stalls
  p_no_zero_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (decRs == '0 && decRt == '0) |-> !stall);

  // R11: writeback write-enable is the accepted decode write-enable, three cycles on
  p_wb_tracks_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbRegWrite == $past(decRegWrite && !bubble, 3));

endmodule

bind hzd_unit hzd_unit_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .decRs       (decRs),
  .decRt       (decRt),
  .decRegWrite (decRegWrite),
  .fwdSelA     (fwdSelA),
  .fwdSelB     (fwdSelB),
  .stall       (stall),
  .bubble      (bubble),
  .wbRegWrite  (wbRegWrite)
);

// File: tb/hzd_unit_tb.sv
`timescale 1ns/1ps
module hzd_unit_tb;

  localparam int W = 5;

  typedef struct {
    logic [1:0]   selA;
    logic [1:0]   selB;
    logic         st;
    logic [W-1:0] wbd;
    logic         wbw;
    string        tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] decRs = '0, decRt = '0, decDst = '0;
  logic decRegWrite = 1'b0, decMemRead = 1'b0;
  logic [1:0] fwdSelA, fwdSelB;
  logic stall, bubble, wbRegWrite;
  logic [W-1:0] wbDst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  expItem_t sbq[$];

  // Reference slots: index 0 execute, 1 memory, 2 writeback
  logic [W-1:0] mRs, mRt;
  logic [W-1:0] mDst [3];
  logic         mRw  [3];
  logic         mMr;

  hzd_unit #(.REG_ADDR_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .decRs(decRs), .decRt(decRt), .decDst(decDst),
    .decRegWrite(decRegWrite), .decMemRead(decMemRead),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB), .stall(stall), .bubble(bubble),
    .wbDst(wbDst), .wbRegWrite(wbRegWrite)
  );

  always #2.5 clk = ~clk;

  function automatic logic [1:0] refSel(input logic [W-1:0] src);
    if (mRw[1] && mDst[1] != '0 && mDst[1] == src) return 2'b10;
    if (mRw[2] && mDst[2] != '0 && mDst[2] == src) return 2'b01;
    return 2'b00;
  endfunction

  task automatic checkOne(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [W-1:0] rs, input logic [W-1:0] rt,
                       input logic [W-1:0] rd, input bit rw, input bit mr,
                       input string tag);
    bit st;
    do begin
      expItem_t e;
      @(negedge clk);
      decRs = rs; decRt = rt; decDst = rd; decRegWrite = rw; decMemRead = mr;
      st = mMr && mDst[0] != '0 && (mDst[0] == rs || mDst[0] == rt);
      e.selA = refSel(mRs);
      e.selB = refSel(mRt);
      e.st   = st;
      e.wbd  = mDst[2];
      e.wbw  = mRw[2];
      e.tag  = tag;
      sbq.push_back(e);
      @(posedge clk);
      mDst[2] = mDst[1]; mRw[2] = mRw[1];
      mDst[1] = mDst[0]; mRw[1] = mRw[0];
      if (st) begin
        mRs = '0; mRt = '0; mDst[0] = '0; mRw[0] = 1'b0; mMr = 1'b0;
      end else begin
        mRs = rs; mRt = rt; mDst[0] = rd; mRw[0] = rw; mMr = mr;
      end
    end while (st);
  endtask

  task automatic nop(input string tag);
    issue('0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each expected item shortly before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() > 0) begin
        expItem_t e;
        string wt;
        e = sbq.pop_front();
        wt = (e.tag == "R1") ? "R1" : "R11";
        checkOne(e.tag, "fwdSelA", 8'(fwdSelA), 8'(e.selA));
        checkOne(e.tag, "fwdSelB", 8'(fwdSelB), 8'(e.selB));
        checkOne(e.tag, "stall",   8'(stall),   8'(e.st));
        checkOne(e.tag, "bubble",  8'(bubble),  8'(e.st));
        checkOne(wt,    "wbDst",   8'(wbDst),   8'(e.wbd));
        checkOne(wt,    "wbRegWrite", 8'(wbRegWrite), 8'(e.wbw));
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mRs = '0; mRt = '0; mMr = 1'b0;
    for (int i = 0; i < 3; i++) begin mDst[i] = '0; mRw[i] = 1'b0; end

    // R1: outputs during reset
    repeat (3) @(posedge clk);
    begin
      expItem_t e;
      @(negedge clk);
      e.selA = 2'b00; e.selB = 2'b00; e.st = 1'b0; e.wbd = '0; e.wbw = 1'b0; e.tag = "R1";
      sbq.push_back(e);
    end
    @(negedge clk);
    rstN = 1'b1;
    nop("R1");

    // R9 / R2 / R3 / R12: ALU producer chain
    issue(5'd1, 5'd2, 5'd3, 1'b1, 1'b0, "R9");
    issue(5'd3, 5'd5, 5'd4, 1'b1, 1'b0, "R9");
    issue(5'd5, 5'd3, 5'd6, 1'b1, 1'b0, "R2");
    nop("R3/R12");
    nop("R11");

    // R4: two writers of r7 in flight
    issue(5'd1, 5'd1, 5'd7, 1'b1, 1'b0, "R4");
    issue(5'd2, 5'd2, 5'd7, 1'b1, 1'b0, "R4");
    issue(5'd7, 5'd7, 5'd9, 1'b1, 1'b0, "R4");
    nop("R4");

    // R5: register 0 writers and loads
    issue(5'd1, 5'd1, 5'd0, 1'b1, 1'b0, "R5");
    issue(5'd0, 5'd0, 5'd8, 1'b1, 1'b0, "R5");
    nop("R5");
    issue(5'd1, 5'd1, 5'd0, 1'b1, 1'b1, "R5");
    issue(5'd0, 5'd0, 5'd2, 1'b1, 1'b0, "R5");
    nop("R5");

    // R6: write-disabled destination
    issue(5'd1, 5'd1, 5'd8, 1'b0, 1'b0, "R6");
    issue(5'd8, 5'd8, 5'd9, 1'b1, 1'b0, "R6");
    nop("R6");

    // R7 / R8: load-use on the second source
    issue(5'd2, 5'd2, 5'd9, 1'b1, 1'b1, "R7");
    issue(5'd4, 5'd9, 5'd10, 1'b1, 1'b0, "R7");
    nop("R8");
    nop("R11");

    // R7: load-use on the first source
    issue(5'd3, 5'd3, 5'd13, 1'b1, 1'b1, "R7");
    issue(5'd13, 5'd0, 5'd14, 1'b1, 1'b0, "R7");
    nop("R8");

    // R10: producer three ahead
    issue(5'd1, 5'd1, 5'd11, 1'b1, 1'b0, "R10");
    nop("R10");
    nop("R10");
    issue(5'd11, 5'd11, 5'd12, 1'b1, 1'b0, "R10");
    nop("R10");

    // drain: R11 writeback tags
    nop("R11");
    nop("R11");
    nop("R11");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule